// File: doc/BRIEF.md
# Protected Page Translation Buffer

This block turns a virtual address into a physical address by looking up the virtual page number in a small, fully associative store of cached page-table entries. Every valid entry is compared against the incoming page number in the same cycle. The selected entry supplies the page frame number, and the page offset is appended unchanged. The lookup result is combinational and is valid in the cycle the request is presented.

Each entry also holds permission and status bits: a kernel-only flag, a write-enable flag, a resident (in-memory) flag, a reference bit and a dirty bit. A hit checks the access against the current privilege mode and the access type. It reports a page fault when the page is not resident and a protection fault when the access is not allowed. A successful access sets the entry's reference bit, and a successful write also sets its dirty bit.

After a miss, an external walker installs the entry through the fill port. The slot it replaces is chosen by a reference-bit approximation of least-recently-used order. A flush input empties the whole buffer in one cycle.

Top module: `xlate_buf`

## Requirements
- R1: On a hit, `rsp_pa_o` equals the entry's page frame number in the upper bits and the request's low `OFF_W` address bits unchanged in the lower bits; on a miss it is zero.
- R2: `rsp_hit_o` is 1 exactly when `req_vld_i` is 1 and a valid entry's stored page number equals the upper `VA_W-OFF_W` bits of `req_va_i`.
- R3: A hit on an entry whose resident flag is 0 raises `rsp_page_fault_o`, never `rsp_prot_fault_o`, and changes neither the reference nor the dirty bit.
- R4: A hit on a resident entry whose kernel-only flag is 1 raises `rsp_prot_fault_o` when `req_kmode_i` is 0 (user mode); it does not fault when `req_kmode_i` is 1.
- R5: A write (`req_wr_i`=1) hitting a resident entry whose write-enable flag is 0 raises `rsp_prot_fault_o` in either mode; a faulting access updates no status bit.
- R6: A granted write sets the entry's dirty bit; `rsp_dirty_o` shows the entry's dirty bit as it stands after the current access (0 on a miss); a fill installs the entry with dirty 0.
- R7: `fill_slot_o` is the lowest-numbered entry whose reference bit is 0 (0 if none); a fill writes that slot and sets its reference bit, and a fill wins over a same-cycle status update to the same slot.
- R8: A granted access sets the hit entry's reference bit; when the updates of a cycle would leave every reference bit set, all reference bits are cleared instead.
- R9: `flush_i` invalidates every entry and clears all reference and dirty bits at the next edge, overriding a same-cycle fill and status update.
- R10: After reset the buffer holds no valid entry, every lookup misses and `fill_slot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| req_vld_i | input | 1 | Lookup request present |
| req_va_i | input | VA_W | Virtual address to translate |
| req_wr_i | input | 1 | 1 = write access, 0 = read access |
| req_kmode_i | input | 1 | 1 = kernel mode, 0 = user mode |
| fill_vld_i | input | 1 | Install an entry into `fill_slot_o` at the next edge |
| fill_vpn_i | input | VA_W-OFF_W | Virtual page number of the new entry |
| fill_pfn_i | input | PA_W-OFF_W | Page frame number of the new entry |
| fill_kern_only_i | input | 1 | New entry reachable only in kernel mode |
| fill_wr_ok_i | input | 1 | New entry writable |
| fill_present_i | input | 1 | New entry resident in memory |
| rsp_hit_o | output | 1 | Lookup matched a valid entry |
| rsp_pa_o | output | PA_W | Translated physical address |
| rsp_page_fault_o | output | 1 | Hit on a non-resident entry |
| rsp_prot_fault_o | output | 1 | Hit whose access rights are violated |
| rsp_dirty_o | output | 1 | Dirty status of the hit entry after this access |
| fill_slot_o | output | $clog2(ENTRIES) | Slot the next fill will replace |

## Verification
The assertions watch, on every cycle, that at most one entry matches, that the two fault kinds never coincide and only occur on a hit, that the proposed victim always has its reference bit clear, that the reference vector never rests fully set, that a flush leaves no valid entry and that a granted write leaves the dirty bit set. The mapping itself, the exact victim order, the clearing of all reference bits when the last one is set, and the precedence of flush and fill over status updates can only be seen by the bench's scenarios. These scenarios compare every output against a behavioural model across fills, mode and access-type sweeps, and random mixes.

// File: rtl/xlate_buf_pkg.sv
package xlate_buf_pkg;
  // permission pair kept per entry
  typedef struct packed {
    logic kern_only;
    logic wr_ok;
  } perm_t;
endpackage

// File: rtl/xb_cam.sv
module xb_cam #(
  parameter int N     = 32,
  parameter int KEY_W = 20,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][KEY_W-1:0] tags,
  input  logic [KEY_W-1:0]        key,
  output logic [N-1:0]            match_vec,
  output logic                    any_match,
  output logic [IDX_W-1:0]        match_idx
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match_vec[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  assign any_match = |match_vec;

  // OR-encode: exact when at most one line matches
  always_comb begin
    match_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/xb_perm_chk.sv
module xb_perm_chk
  import xlate_buf_pkg::*;
(
  input  logic  hit,
  input  logic  present,
  input  perm_t perm,
  input  logic  kmode,
  input  logic  wr,
  output logic  page_fault,
  output logic  prot_fault,
  output logic  grant
);
  logic violation;

  always_comb begin
    violation  = (perm.kern_only && !kmode) || (wr && !perm.wr_ok);
    page_fault = hit && !present;
    prot_fault = hit && present && violation;
    grant      = hit && present && !violation;
  end
endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     ref_vec,
  output logic [IDX_W-1:0] victim
);
  // lowest-numbered entry with reference clear
  always_comb begin
    victim = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ref_vec[i]) victim = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_buf_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 32,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_vld_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_wr_i,
  input  logic             req_kmode_i,
  input  logic             fill_vld_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_kern_only_i,
  input  logic             fill_wr_ok_i,
  input  logic             fill_present_i,
  output logic             rsp_hit_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic             rsp_dirty_o,
  output logic [IDX_W-1:0] fill_slot_o
);
  // entry state
  logic [ENTRIES-1:0]            vld_q, vld_d;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q, pfn_d;
  perm_t [ENTRIES-1:0]           perm_q, perm_d;
  logic [ENTRIES-1:0]            pres_q, pres_d;
  logic [ENTRIES-1:0]            ref_q, ref_d;
  logic [ENTRIES-1:0]            dirty_q, dirty_d;

  logic [ENTRIES-1:0] match_vec;
  logic               cam_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               hit, grant;
  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] ref_set;
  logic               fill_en;

  assign req_vpn = req_va_i[VA_W-1:OFF_W];

  xb_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam (
    .valid     (vld_q),
    .tags      (tag_q),
    .key       (req_vpn),
    .match_vec (match_vec),
    .any_match (cam_hit),
    .match_idx (hit_idx)
  );

  assign hit = req_vld_i && cam_hit;

  xb_perm_chk u_perm (
    .hit        (hit),
    .present    (pres_q[hit_idx]),
    .perm       (perm_q[hit_idx]),
    .kmode      (req_kmode_i),
    .wr         (req_wr_i),
    .page_fault (rsp_page_fault_o),
    .prot_fault (rsp_prot_fault_o),
    .grant      (grant)
  );

  xb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .ref_vec (ref_q),
    .victim  (fill_slot_o)
  );

  assign rsp_hit_o   = hit;
  assign rsp_pa_o    = hit ? {pfn_q[hit_idx], req_va_i[OFF_W-1:0]} : '0;
  assign rsp_dirty_o = hit && (dirty_q[hit_idx] || (grant && req_wr_i));
  assign fill_en     = fill_vld_i && !flush_i;

  // next state: status update, then fill, then saturation, flush last
  always_comb begin
    vld_d   = vld_q;
    tag_d   = tag_q;
    pfn_d   = pfn_q;
    perm_d  = perm_q;
    pres_d  = pres_q;
    ref_set = ref_q;
    dirty_d = dirty_q;
    if (grant) begin
      ref_set[hit_idx] = 1'b1;
      if (req_wr_i) dirty_d[hit_idx] = 1'b1;
    end
    if (fill_en) begin
      vld_d[fill_slot_o]   = 1'b1;
      tag_d[fill_slot_o]   = fill_vpn_i;
      pfn_d[fill_slot_o]   = fill_pfn_i;
      perm_d[fill_slot_o]  = '{kern_only: fill_kern_only_i, wr_ok: fill_wr_ok_i};
      pres_d[fill_slot_o]  = fill_present_i;
      ref_set[fill_slot_o] = 1'b1;
      dirty_d[fill_slot_o] = 1'b0;
    end
    ref_d = (&ref_set) ? '0 : ref_set;
    if (flush_i) begin
      vld_d   = '0;
      ref_d   = '0;
      dirty_d = '0;
    end
  end

  // status registers, reset to empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  // payload registers, loaded only by a fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      pfn_q  <= '0;
      perm_q <= '0;
      pres_q <= '0;
    end else if (fill_en) begin
      tag_q  <= tag_d;
      pfn_q  <= pfn_d;
      perm_q <= perm_d;
      pres_q <= pres_d;
    end
  end

  // checks next to the logic
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r3_fault_kinds_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_page_fault_o && rsp_prot_fault_o));

  a_r3_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_page_fault_o || rsp_prot_fault_o) |-> rsp_hit_o);

  a_r7_victim_unreferenced: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_q[fill_slot_o]);

  a_r8_ref_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ref_q));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));

  a_r6_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_wr_i && !flush_i && !(fill_vld_i && (fill_slot_o == hit_idx)))
      |=> dirty_q[$past(hit_idx)]);
endmodule

// File: tb/xlate_buf_tb_top.sv
module xlate_buf_tb_top;
  localparam int VA_W = 32, PA_W = 32, OFF_W = 12, N = 32;
  localparam int VPN_W = VA_W - OFF_W, PFN_W = PA_W - OFF_W, IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic flush, rvld, rwr, kmode, fvld, fko, fwo, fpr;
  logic [VA_W-1:0]  va;
  logic [VPN_W-1:0] fvpn;
  logic [PFN_W-1:0] fpfn;
  logic             hit, pf, prf, dty;
  logic [PA_W-1:0]  pa;
  logic [IDX_W-1:0] slot;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // behavioural model state
  bit m_vld[N], m_ko[N], m_wo[N], m_pr[N], m_ref[N], m_dt[N];
  int m_vpn[N], m_pfn[N];

  always #10 clk = ~clk;

  xlate_buf dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .req_vld_i(rvld), .req_va_i(va), .req_wr_i(rwr), .req_kmode_i(kmode),
    .fill_vld_i(fvld), .fill_vpn_i(fvpn), .fill_pfn_i(fpfn),
    .fill_kern_only_i(fko), .fill_wr_ok_i(fwo), .fill_present_i(fpr),
    .rsp_hit_o(hit), .rsp_pa_o(pa), .rsp_page_fault_o(pf),
    .rsp_prot_fault_o(prf), .rsp_dirty_o(dty), .fill_slot_o(slot)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    flush = 0; rvld = 0; rwr = 0; kmode = 0; fvld = 0;
    fko = 0; fwo = 0; fpr = 0; va = '0; fvpn = '0; fpfn = '0;
  endtask

  // called just after a falling edge with inputs set
  task automatic step();
    bit e_hit, e_pf, e_prf, e_ok, e_dt, allset;
    int h, vic;
    logic [PA_W-1:0] e_pa;
    #5;
    e_hit = 0; h = 0;
    if (rvld)
      for (int i = 0; i < N; i++)
        if (m_vld[i] && m_vpn[i] == int'(va[VA_W-1:OFF_W])) begin e_hit = 1; h = i; end
    e_pf  = e_hit && !m_pr[h];
    e_prf = e_hit && m_pr[h] && ((m_ko[h] && !kmode) || (rwr && !m_wo[h]));
    e_ok  = e_hit && m_pr[h] && !e_prf;
    e_pa  = e_hit ? {m_pfn[h][PFN_W-1:0], va[OFF_W-1:0]} : '0;
    e_dt  = e_hit && (m_dt[h] || (e_ok && rwr));
    vic = 0;
    for (int i = N - 1; i >= 0; i--) if (!m_ref[i]) vic = i;
    chk("R2", "hit", 64'(hit), 64'(e_hit));
    chk("R1", "pa", 64'(pa), 64'(e_pa));
    chk("R3", "page_fault", 64'(pf), 64'(e_pf));
    chk("R4 R5", "prot_fault", 64'(prf), 64'(e_prf));
    chk("R6", "dirty", 64'(dty), 64'(e_dt));
    chk("R7 R8 R9 R10", "fill_slot", 64'(slot), 64'(vic));
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_ref[i] = 0; m_dt[i] = 0; end
    end else begin
      if (e_ok) begin m_ref[h] = 1; if (rwr) m_dt[h] = 1; end
      if (fvld) begin
        m_vld[vic] = 1; m_vpn[vic] = int'(fvpn); m_pfn[vic] = int'(fpfn);
        m_ko[vic] = fko; m_wo[vic] = fwo; m_pr[vic] = fpr;
        m_ref[vic] = 1; m_dt[vic] = 0;
      end
      allset = 1;
      for (int i = 0; i < N; i++) if (!m_ref[i]) allset = 0;
      if (allset) for (int i = 0; i < N; i++) m_ref[i] = 0;
    end
    @(negedge clk);
  endtask

  task automatic lookup(int vpn, bit w, bit k);
    rvld = 1; rwr = w; kmode = k;
    va = {VPN_W'(vpn), OFF_W'($urandom)};
  endtask

  task automatic fill(int vpn, int pfn, bit ko, bit wo, bit pr);
    fvld = 1; fvpn = VPN_W'(vpn); fpfn = PFN_W'(pfn); fko = ko; fwo = wo; fpr = pr;
  endtask

  initial begin
    int fresh;
    void'($urandom(7));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ref[i] = 0; m_dt[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
      m_ko[i] = 0; m_wo[i] = 0; m_pr[i] = 0;
    end
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: empty after reset
    lookup(0, 0, 1); step(); idle();
    lookup(5, 1, 0); step(); idle();
    // R7/R8: fill every slot; last fill saturates and clears references
    for (int i = 0; i < N; i++) begin
      fill(i * 7 + 3, i * 13 + 256, (i % 4) == 1, (i % 3) != 0, (i % 5) != 4);
      lookup(9999, 0, 0);
      step(); idle();
    end
    // R1-R6: sweep entries across modes and access types
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < N; i++) begin
        lookup(i * 7 + 3, k[0], k[1]); step(); idle();
      end
    // R3 R4 R5 R6 R7 R8: random mix, fills with fresh page numbers
    fresh = 5000;
    for (int n = 0; n < 600; n++) begin
      int pick = $urandom_range(0, 9);
      if (pick < 7) lookup(m_vpn[$urandom_range(0, N - 1)], $urandom_range(0, 1), $urandom_range(0, 1));
      else if (pick == 7) lookup(fresh + 77, 0, 0);
      if ($urandom_range(0, 3) == 0) begin
        fill(fresh, $urandom, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) != 0);
        fresh++;
      end
      step(); idle();
    end
    // R9: flush overrides a same-cycle fill and update
    lookup(m_vpn[0], 1, 1);
    fill(fresh, 42, 0, 1, 1); flush = 1; step(); idle(); fresh++;
    lookup(m_vpn[0], 0, 1); step(); idle();
    lookup(fresh - 1, 0, 1); step(); idle();
    // refill after flush, R6 dirty cleared on fill
    for (int i = 0; i < 6; i++) begin
      fill(fresh + i, 900 + i, 0, 1, 1); step(); idle();
    end
    for (int i = 0; i < 6; i++) begin
      lookup(fresh + i, 1, 0); step(); idle();
      lookup(fresh + i, 0, 0); step(); idle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule